// File: doc/BRIEF.md
# Reloading Up-Timer with Read Latch

This block is a 16-bit timer that counts upward from a programmable start value. When the count passes its all-ones value it does not stop at zero. It reloads itself from a start-value register and raises a one-cycle overflow pulse, so other logic can use it as a periodic event source. The count advances on one of two sources, chosen by a select bit. One source is a 1 MHz tick enable that is already in the system clock domain. The other is an external clock pin, which is asynchronous and shared with other functions. The pin is synchronised to the system clock, and each rising edge advances the count once.

The host never touches the running counter directly. It writes the start value as two bytes and can force the counter to that value with a load strobe. To read the count, the host issues a snapshot command and then reads the frozen snapshot one byte at a time. The snapshot holds from the command until the upper byte has been read, so the two bytes always belong to the same count.

Top module: `reload_timer`

## Requirements
- R1: After reset the counter, the start-value register and the snapshot are all zero, `rd_data` reads 0 for both byte selects, and `ovf_pulse` is low.
- R2: With `src_ext` = 0, the counter increases by exactly one on each clock cycle in which `tick_1mhz` is high, and holds otherwise.
- R3: A count step taken while the counter is at 0xFFFF loads the start value instead. `ovf_pulse` is high for exactly the one cycle in which the counter first shows the reloaded value, so it is high once per wrap.
- R4: A write with `wr_hi` = 0 only stages the low byte. A write with `wr_hi` = 1 commits {high byte, staged low byte} to the start-value register. A low-byte write alone leaves the start value unchanged.
- R5: `load_start` copies the start value into the counter on the next edge. It takes priority over a count step in the same cycle, and that cycle produces no overflow pulse.
- R6: `latch_cmd` copies the current count into the snapshot. `rd_data` returns snapshot bits 7:0 when `rd_hi` = 0 and bits 15:8 when `rd_hi` = 1.
- R7: Once taken, the snapshot stays unchanged until a cycle with `rd_en` = 1 and `rd_hi` = 1. Any `latch_cmd` issued before then is ignored, even while the counter runs.
- R8: With `src_ext` = 1, the counter advances once per rising edge of `ext_clk_pin`, after a two-flop synchroniser, and `tick_1mhz` is ignored. With `src_ext` = 0, `ext_clk_pin` has no effect.
- R9: Writes to the start-value register never change the counter. Only `load_start` and a wrap move the start value into the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1mhz | input | 1 | Internal 1 MHz count enable, one cycle wide |
| ext_clk_pin | input | 1 | Asynchronous external clock pin (shared) |
| src_ext | input | 1 | Count source select: 0 internal tick, 1 external pin |
| wr_en | input | 1 | Start-value byte write strobe |
| wr_hi | input | 1 | Write byte select: 0 low byte, 1 high byte (commits) |
| wr_data | input | 8 | Write byte |
| load_start | input | 1 | Copy start value into counter |
| latch_cmd | input | 1 | Take a snapshot of the count |
| rd_en | input | 1 | Snapshot byte read strobe |
| rd_hi | input | 1 | Read byte select: 0 low byte, 1 high byte |
| rd_data | output | 8 | Selected snapshot byte |
| ovf_pulse | output | 1 | One-cycle pulse on each wrap |

## Verification
The assertions assume three things about the inputs. Every input except `ext_clk_pin` is driven synchronously to `clk`. Inputs are driven from time zero, so the first cycle after reset sees defined values. `ext_clk_pin` is held low through reset. The stimulus changes every input at the falling edge, leaves the pin low until the source-select test, and holds each pin level for three cycles so that every edge passes through the synchroniser. The snapshot checks always read the low byte before the high byte. The hold test places count steps and a second snapshot command between those two reads.

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1mhz,
  input  logic              ext_clk_pin,
  input  logic              src_ext,
  input  logic              wr_en,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              load_start,
  input  logic              latch_cmd,
  input  logic              rd_en,
  input  logic              rd_hi,
  output logic [BYTE_W-1:0] rd_data,
  output logic              ovf_pulse
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [2:0]        ext_sync;
  logic              ext_rise, cnt_en, at_max;
  logic [CNT_W-1:0]  cnt_q, reload_q, latch_q;
  logic [BYTE_W-1:0] lo_stage;
  logic              lock_q, take, release_lock;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ext_sync <= '0;
    else        ext_sync <= {ext_sync[1:0], ext_clk_pin};

  assign ext_rise = ext_sync[1] & ~ext_sync[2];
  assign cnt_en   = src_ext ? ext_rise : tick_1mhz;
  assign at_max   = (cnt_q == MAXV);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q     <= '0;
      ovf_pulse <= 1'b0;
    end else begin
      ovf_pulse <= cnt_en && at_max && !load_start;
      if (load_start)  cnt_q <= reload_q;
      else if (cnt_en) cnt_q <= at_max ? reload_q : cnt_q + CNT_W'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lo_stage <= '0;
      reload_q <= '0;
    end else if (wr_en) begin
      if (wr_hi) reload_q <= {wr_data, lo_stage};
      else       lo_stage <= wr_data;
    end

  assign take         = latch_cmd && !lock_q;
  assign release_lock = rd_en && rd_hi;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      latch_q <= '0;
      lock_q  <= 1'b0;
    end else if (take) begin
      latch_q <= cnt_q;
      lock_q  <= 1'b1;
    end else if (release_lock) begin
      lock_q  <= 1'b0;
    end

  assign rd_data = rd_hi ? latch_q[CNT_W-1:BYTE_W] : latch_q[BYTE_W-1:0];

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en && !load_start && !at_max |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load_start) && !$past(cnt_en) |-> $stable(cnt_q));

  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en && !load_start && at_max |=> ovf_pulse && cnt_q == $past(reload_q));

  // R3
  no_spurious_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> $past(at_max) && $past(cnt_en) && !$past(load_start));

  // R5
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_start |=> cnt_q == $past(reload_q) && !ovf_pulse);

  // R4
  reload_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en && wr_hi) |-> $stable(reload_q));

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock_q) |-> $stable(latch_q));
endmodule

// File: tb/reload_timer_bench.sv
module reload_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1mhz = 1'b0, ext_clk_pin = 1'b0, src_ext = 1'b0;
  logic wr_en = 1'b0, wr_hi = 1'b0, load_start = 1'b0, latch_cmd = 1'b0;
  logic rd_en = 1'b0, rd_hi = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic ovf_pulse;

  int checks = 0;
  int fails = 0;
  int ovf_seen = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  reload_timer u_reload_timer (
    .clk(clk), .rst_n(rst_n), .tick_1mhz(tick_1mhz), .ext_clk_pin(ext_clk_pin),
    .src_ext(src_ext), .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
    .load_start(load_start), .latch_cmd(latch_cmd), .rd_en(rd_en), .rd_hi(rd_hi),
    .rd_data(rd_data), .ovf_pulse(ovf_pulse)
  );

  always @(negedge clk) if (rst_n && ovf_pulse) ovf_seen++;

  // {start value, count steps, expected count, expected wraps}
  localparam logic [63:0] VEC [8] = '{
    {16'h0000, 16'd5,   16'h0005, 16'd0},
    {16'h1234, 16'd0,   16'h1234, 16'd0},
    {16'hFFFE, 16'd1,   16'hFFFF, 16'd0},
    {16'hFFFE, 16'd2,   16'hFFFE, 16'd1},
    {16'hFFF0, 16'd20,  16'hFFF4, 16'd1},
    {16'hFFFF, 16'd3,   16'hFFFF, 16'd3},
    {16'hFFFC, 16'd9,   16'hFFFD, 16'd2},
    {16'hA5C3, 16'd300, 16'hA6EF, 16'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_start(input logic [15:0] v);
    wr_en = 1'b1; wr_hi = 1'b0; wr_data = v[7:0];
    @(negedge clk);
    wr_hi = 1'b1; wr_data = v[15:8];
    @(negedge clk);
    wr_en = 1'b0; wr_hi = 1'b0;
  endtask

  task automatic do_load();
    load_start = 1'b1;
    @(negedge clk);
    load_start = 1'b0;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) begin
      tick_1mhz = 1'b1;
      @(negedge clk);
    end
    tick_1mhz = 1'b0;
  endtask

  task automatic snap(output logic [15:0] v);
    latch_cmd = 1'b1;
    @(negedge clk);
    latch_cmd = 1'b0; rd_en = 1'b1; rd_hi = 1'b0;
    #1 v[7:0] = rd_data;
    @(negedge clk);
    rd_hi = 1'b1;
    #1 v[15:8] = rd_data;
    @(negedge clk);
    rd_en = 1'b0; rd_hi = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual timeout expected finish");
      finish_run();
    end
  end

  initial begin
    logic [15:0] got;
    logic [7:0]  b;
    int o0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_hi = 1'b0; #1 check("R1 snapshot low", {24'h0, rd_data}, 32'h0);
    rd_hi = 1'b1; #1 check("R1 snapshot high", {24'h0, rd_data}, 32'h0);
    rd_hi = 1'b0;
    check("R1 ovf low", {31'h0, ovf_pulse}, 32'h0);
    @(negedge clk);
    snap(got);
    check("R1 counter zero", {16'h0, got}, 32'h0);

    // R2 R3 R6 table walk
    foreach (VEC[k]) begin
      wr_start(VEC[k][63:48]);
      do_load();
      o0 = ovf_seen;
      steps(int'(VEC[k][47:32]));
      snap(got);
      check("R2/R3/R6 count", {16'h0, got}, {16'h0, VEC[k][31:16]});
      check("R3 wrap pulses", ovf_seen - o0, {16'h0, VEC[k][15:0]});
    end

    // R7 snapshot held across steps and a second command
    wr_start(16'h12FF);
    do_load();
    latch_cmd = 1'b1;
    @(negedge clk);
    latch_cmd = 1'b0; rd_en = 1'b1; rd_hi = 1'b0;
    #1 b = rd_data;
    check("R7 low byte", {24'h0, b}, 32'hFF);
    @(negedge clk);
    rd_en = 1'b0;
    steps(2);
    latch_cmd = 1'b1;
    @(negedge clk);
    latch_cmd = 1'b0; rd_en = 1'b1; rd_hi = 1'b1;
    #1 b = rd_data;
    check("R7 high byte held", {24'h0, b}, 32'h12);
    @(negedge clk);
    rd_en = 1'b0; rd_hi = 1'b0;
    snap(got);
    check("R7 new snapshot after release", {16'h0, got}, 32'h1301);

    // R8 external source
    wr_start(16'h0040);
    do_load();
    src_ext = 1'b1; tick_1mhz = 1'b1;
    for (int i = 0; i < 4; i++) begin
      ext_clk_pin = 1'b1; repeat (3) @(negedge clk);
      ext_clk_pin = 1'b0; repeat (3) @(negedge clk);
    end
    tick_1mhz = 1'b0;
    repeat (4) @(negedge clk);
    snap(got);
    check("R8 external edges counted, tick ignored", {16'h0, got}, 32'h0044);
    src_ext = 1'b0;
    for (int i = 0; i < 3; i++) begin
      ext_clk_pin = 1'b1; repeat (3) @(negedge clk);
      ext_clk_pin = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    snap(got);
    check("R8 pin ignored on internal source", {16'h0, got}, 32'h0044);

    // R4 low byte alone does not commit
    wr_en = 1'b1; wr_hi = 1'b0; wr_data = 8'h77;
    @(negedge clk);
    wr_en = 1'b0;
    do_load();
    snap(got);
    check("R4 low byte only", {16'h0, got}, 32'h0040);
    wr_en = 1'b1; wr_hi = 1'b1; wr_data = 8'hAB;
    @(negedge clk);
    wr_en = 1'b0; wr_hi = 1'b0;
    do_load();
    snap(got);
    check("R4 high byte commits", {16'h0, got}, 32'hAB77);

    // R9 start-value writes leave counter alone
    wr_start(16'hFFFF);
    do_load();
    wr_start(16'h0100);
    snap(got);
    check("R9 counter untouched by write", {16'h0, got}, 32'hFFFF);

    // R5 load wins over a step at 0xFFFF, no pulse
    o0 = ovf_seen;
    load_start = 1'b1; tick_1mhz = 1'b1;
    @(negedge clk);
    load_start = 1'b0; tick_1mhz = 1'b0;
    snap(got);
    check("R5 load priority value", {16'h0, got}, 32'h0100);
    check("R5 no pulse on load", ovf_seen - o0, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule